// File: doc/BRIEF.md
# Four-Bit Ripple Adder/Subtractor

This block adds or subtracts two 4-bit two's-complement operands. A single mode input selects the operation. With the mode low, the operands are summed. With the mode high, the second operand is inverted bit by bit and a one is injected as the initial carry, so the chain forms the first operand plus the two's complement of the second.

The chain is a row of 1-bit full adders with carries rippling from the least significant stage upward. Each full adder is built from two half adders and an OR gate. The final carry leaves the block as the carry-out. A signed overflow flag is formed by comparing the carry entering the top stage with the carry leaving it.

The block is purely combinational. It suits a small datapath that needs one shared add/subtract unit, where a narrow operand width makes ripple delay acceptable.

Top module: `ripple_addsub`

## Requirements
- R1: With subMode = 0, {carryOut, result} equals opA + opB taken as unsigned 5-bit values.
- R2: With subMode = 1, result equals (opA - opB) modulo 16.
- R3: With subMode = 1, carryOut is 1 exactly when opA >= opB as unsigned numbers, meaning no borrow occurred.
- R4: With subMode = 0, overflow is 1 exactly when the signed sum of opA and opB (each read as -8..7) lies outside -8..7.
- R5: With subMode = 1, overflow is 1 exactly when the signed difference opA - opB lies outside -8..7.
- R6: A carry crosses every stage: 4'b1111 + 4'b0001 gives result 0, carryOut 1 and overflow 0. Likewise 0 - 0 gives result 0 and carryOut 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First operand, two's complement |
| opB | input | 4 | Second operand, two's complement |
| subMode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 4 | Sum or difference, modulo 16 |
| carryOut | output | 1 | Carry leaving the top stage; in subtraction, 1 means no borrow |
| overflow | output | 1 | Signed overflow of the selected operation |

## Verification
The assertions check the following on every evaluation:
- Each full adder's two outputs match the arithmetic sum of its three inputs.
- The control always drives both strobes from the mode.
- The top-level result and carry match a wide arithmetic reference.
- The overflow flag agrees with a rule based on operand and result signs.

The bench's scenarios cover what those local checks cannot prove. It sweeps all 512 operand and mode combinations against signed and unsigned reference arithmetic. It also checks the no-borrow meaning of the carry in subtraction and the full-length carry ripple cases.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned DATA_W = 4;

  typedef struct packed {
    logic invertB;
    logic carryIn;
  } addsub_strobe_t;
endpackage

// File: rtl/ras_half_adder.sv
module ras_half_adder (
  input  logic inX,
  input  logic inY,
  output logic sumOut,
  output logic carryOut
);
  assign sumOut   = inX ^ inY;
  assign carryOut = inX & inY;
endmodule

// File: rtl/ras_full_adder.sv
module ras_full_adder (
  input  logic bitA,
  input  logic bitB,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);
  logic halfSum;
  logic halfCarryLo;
  logic halfCarryHi;

  ras_half_adder u_haLo (
    .inX(bitA), .inY(bitB), .sumOut(halfSum), .carryOut(halfCarryLo)
  );
  ras_half_adder u_haHi (
    .inX(halfSum), .inY(carryIn), .sumOut(sumOut), .carryOut(halfCarryHi)
  );

  assign carryOut = halfCarryLo | halfCarryHi;

  // Stage arithmetic check, supports R1 and R2
  always_comb begin
    a_stage_sum_r1: assert ({carryOut, sumOut} ==
                            2'(bitA) + 2'(bitB) + 2'(carryIn))
      else $error("full adder stage mismatch");
  end
endmodule

// File: rtl/ras_control.sv
module ras_control
  import ras_pkg::*;
(
  input  logic           subMode,
  output addsub_strobe_t strobe
);
  always_comb begin
    strobe.invertB = subMode;
    strobe.carryIn = subMode;
  end

  // R2: subtraction needs both inversion and injected carry together
  always_comb begin
    a_strobe_pair_r2: assert (strobe.invertB == strobe.carryIn)
      else $error("strobes disagree");
  end
endmodule

// File: rtl/ras_datapath.sv
module ras_datapath
  import ras_pkg::*;
#(
  parameter int unsigned WIDTH   = DATA_W,
  parameter bit          USE_MUX = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addsub_strobe_t   strobe,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] bEff;

  assign carryChain[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (USE_MUX) begin : g_mux
      assign bEff[i] = strobe.invertB ? ~opB[i] : opB[i];
    end else begin : g_xor
      assign bEff[i] = opB[i] ^ strobe.invertB;
    end
    ras_full_adder u_fa (
      .bitA(opA[i]), .bitB(bEff[i]), .carryIn(carryChain[i]),
      .sumOut(result[i]), .carryOut(carryChain[i+1])
    );
  end

  assign carryOut = carryChain[WIDTH];
  assign overflow = carryChain[WIDTH] ^ carryChain[TOP];

  // R4/R5: overflow agrees with sign rule on effective operands
  always_comb begin
    a_ovf_sign_r4: assert (overflow ==
        ((opA[TOP] == bEff[TOP]) && (result[TOP] != opA[TOP])))
      else $error("overflow disagrees with sign rule");
  end
endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub
  import ras_pkg::*;
#(
  parameter int unsigned WIDTH   = DATA_W,
  parameter bit          USE_MUX = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  addsub_strobe_t strobe;

  ras_control u_ctrl (
    .subMode(subMode), .strobe(strobe)
  );

  ras_datapath #(.WIDTH(WIDTH), .USE_MUX(USE_MUX)) u_dp (
    .opA(opA), .opB(opB), .strobe(strobe),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  logic [WIDTH:0] refWide;
  always_comb begin
    if (subMode) refWide = {1'b0, opA} + {1'b0, ~opB} + 1'b1;
    else         refWide = {1'b0, opA} + {1'b0, opB};
    a_add_ref_r1: assert (subMode || ({carryOut, result} == refWide))
      else $error("sum mismatch");
    a_sub_ref_r2: assert (!subMode || (result == refWide[WIDTH-1:0]))
      else $error("difference mismatch");
    a_noborrow_r3: assert (!subMode || (carryOut == (opA >= opB)))
      else $error("borrow flag mismatch");
  end
endmodule

// File: tb/ripple_addsub_tb.sv
module ripple_addsub_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] opA, opB, result;
  logic       subMode, carryOut, overflow;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ripple_addsub u_dut (
    .opA(opA), .opB(opB), .subMode(subMode),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: A=%0d B=%0d sub=%0d actual=%0d expected=%0d",
               req, opA, opB, subMode, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit s);
    @(negedge clk);
    opA = 4'(a); opB = 4'(b); subMode = s;
    #1;
  endtask

  // R1 and R4: every addition
  task automatic test_add_all();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int sa, sb, sr;
        apply(a, b, 1'b0);
        sa = (a > 7) ? a - 16 : a;
        sb = (b > 7) ? b - 16 : b;
        sr = sa + sb;
        check("R1 sum", {27'd0, carryOut, result}, a + b);
        check("R4 overflow", int'(overflow), int'(sr > 7 || sr < -8));
      end
    end
  endtask

  // R2, R3 and R5: every subtraction
  task automatic test_sub_all();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int sa, sb, sr;
        apply(a, b, 1'b1);
        sa = (a > 7) ? a - 16 : a;
        sb = (b > 7) ? b - 16 : b;
        sr = sa - sb;
        check("R2 difference", int'(result), (a - b + 16) % 16);
        check("R3 no-borrow", int'(carryOut), int'(a >= b));
        check("R5 overflow", int'(overflow), int'(sr > 7 || sr < -8));
      end
    end
  endtask

  // R6: carry travels the full chain
  task automatic test_full_ripple();
    apply(15, 1, 1'b0);
    check("R6 ripple result", int'(result), 0);
    check("R6 ripple carry", int'(carryOut), 1);
    check("R6 ripple overflow", int'(overflow), 0);
    apply(0, 0, 1'b1);
    check("R6 zero-sub result", int'(result), 0);
    check("R6 zero-sub carry", int'(carryOut), 1);
    check("R6 zero-sub overflow", int'(overflow), 0);
  endtask

  // Boundary signed cases for R4 and R5
  task automatic test_signed_edges();
    apply(7, 1, 1'b0);
    check("R4 7+1 overflow", int'(overflow), 1);
    apply(8, 8, 1'b0);
    check("R4 -8+-8 overflow", int'(overflow), 1);
    check("R1 -8+-8 carry", int'(carryOut), 1);
    apply(0, 8, 1'b1);
    check("R5 0-(-8) overflow", int'(overflow), 1);
    apply(8, 1, 1'b1);
    check("R5 -8-1 overflow", int'(overflow), 1);
    apply(7, 15, 1'b1);
    check("R5 7-(-1) overflow", int'(overflow), 1);
    check("R3 7-15 borrow", int'(carryOut), 0);
  endtask

  initial begin
    opA = '0; opB = '0; subMode = 1'b0;
    #1;
    check("R1 initial zero result", int'(result), 0);
    check("R1 initial zero carry", int'(carryOut), 0);
    check("R4 initial zero overflow", int'(overflow), 0);
    test_add_all();
    test_sub_all();
    test_full_ripple();
    test_signed_edges();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule